// File: doc/BRIEF.md
# NVM Page Erase and Program Sequencer

This block runs page-granular program and erase operations on a nonvolatile store of 32 pages, each 16 bytes wide. An I2C target front end feeds it three kinds of event: single-byte register writes, page program requests that carry a whole page of data, and a strobe for every Stop condition seen on the bus. The store is modelled as a register array, and the length of the self-timed cycle is a parameter so that simulation stays short.

An erase is set up in two steps. First a byte is written to the erase control register, which sets the enable bit and selects a page. The erase then starts on the next Stop strobe. When the erase finishes, the enable bit clears itself. Programming can only set bits away from the erased value of 0, and each byte accepts one program between erases. The upper half of the page index selects the user area and the lower half selects the configuration area. In the configuration area, page 15 is read-only, and page 14 becomes protected after a reset if its lock bit has been programmed.

The block has two resets. `rst_n` is a soft reset: it keeps the store and reloads the lock. `por_n` models power-up of a blank part and clears the store as well.

Top module: `nvm_page_sequencer`

## Requirements
- R1: The erase control register responds to register address 0xE3. A write to it stores bit 7 (erase enable) and bits 4:0 (page index). Bits 6:5 always read 0. Writes to any other address leave the register unchanged.
- R2: Writing the enable bit never starts an erase by itself. The erase begins only on a Stop strobe that arrives while the enable bit is set. A Stop strobe with the enable bit clear does nothing.
- R3: An accepted program or erase raises `busy` on the clock edge that accepts it. `busy` then stays high for exactly CYCLE_LEN cycles. The store update becomes visible on the edge where `busy` falls.
- R4: An erase sets all 16 bytes of the selected page to 0x00 and clears the enable bit when it completes. Page index bit 4 picks the space: 1 selects the user area and 0 selects the configuration area.
- R5: The erased state of every byte reads 0x00. A program writes byte k of `prog_data` (bits 8k+7:8k) into byte k of the addressed page, and bits already at 1 stay at 1.
- R6: Each byte accepts one program between erases. A second program of a byte leaves its value unchanged. After an erase, the byte can be programmed again.
- R7: A program request whose address bits 3:0 are not zero is ignored. `busy` stays low and the store does not change.
- R8: Any program or erase request that arrives while `busy` is high is rejected. A Stop strobe with the enable bit set during `busy` clears the enable bit and starts no erase.
- R9: Configuration page 15 (page index 15) rejects both program and erase.
- R10: Configuration page 14 is protected once bit 0 of its byte 0 has been programmed to 1 and a reset has followed. Before that reset, the page can still be written.
- R11: The store and the erase control register can be read while `busy` is high. A soft reset keeps the store contents. `por_n` clears the whole store to 0x00 and removes the lock.
- R12: An armed erase aimed at a protected page clears the enable bit on the Stop strobe and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-up reset, active low; also clears the store |
| rst_n | input | 1 | Synchronous soft reset, active low; keeps the store and reloads the lock |
| reg_wr | input | 1 | Register byte write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 8 | Register write data |
| stop_evt | input | 1 | One-cycle strobe for a bus Stop condition |
| prog_req | input | 1 | Page program request strobe |
| prog_addr | input | ADDR_W (9) | Byte address of the program target; must be page aligned |
| prog_data | input | DATA_W (128) | Page data; byte k at bits 8k+7:8k |
| rd_addr | input | ADDR_W (9) | Byte address for reading the store |
| rd_data | output | 8 | Store byte at `rd_addr` (combinational) |
| erase_ctl | output | 8 | Current value of the erase control register |
| busy | output | 1 | High while a self-timed cycle runs |

## Verification
The assertions check several rules on every cycle:
- the reserved bits of the control register stay at 0;
- every `busy` period lasts exactly CYCLE_LEN cycles;
- `busy` only rises after a request strobe;
- an erase leaves the enable bit clear when it completes;
- no commit ever targets configuration page 15;
- a byte seen at one read address never loses a 1 bit except through an erase commit.

Other behaviour depends on a sequence of operations, so only the bench scenarios can show it. These are:
- the program-once rule;
- rejection while `busy` is high;
- the lock, which takes effect only after a reset;
- retention of the store across a soft reset and clearing on power-up;
- the exact byte placement of program data.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2
    } nvm_op_e;

    // register word address of the erase control byte
    localparam logic [7:0] ERASE_CTL_ADDR = 8'hE3;
    // writable bits of the erase control byte: enable (7) and page (4:0)
    localparam logic [7:0] ERASE_CTL_MASK = 8'h9F;
    localparam int unsigned ERASE_EN_BIT  = 7;

    // configuration-space pages with fixed access rules
    localparam int unsigned CFG_LOCK_PAGE = 14;
    localparam int unsigned CFG_RO_PAGE   = 15;

endpackage

// File: rtl/nvm_cycle_timer.sv
module nvm_cycle_timer #(
    parameter int unsigned CYCLE_LEN = 20,
    localparam int unsigned CNT_W = $clog2(CYCLE_LEN + 1)
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    // the final busy cycle is the one where the down-counter sits at zero
    assign done = tmr_q.busy && (tmr_q.cnt == '0);
    assign busy = tmr_q.busy;

    always_comb begin
        tmr_d = tmr_q;
        if (start && !tmr_q.busy) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CNT_W'(CYCLE_LEN - 1);
        end else if (done) begin
            tmr_d.busy = 1'b0;
        end else if (tmr_q.busy) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/nvm_page_guard.sv
module nvm_page_guard
    import nvm_seq_pkg::*;
#(
    parameter int unsigned PAGE_W = 5
) (
    input  logic [PAGE_W-1:0] page,
    input  logic              lock,
    output logic              allowed
);

    logic              user_space;
    logic [PAGE_W-2:0] local_idx;

    assign user_space = page[PAGE_W-1];
    assign local_idx  = page[PAGE_W-2:0];

    always_comb begin
        allowed = 1'b1;
        if (!user_space) begin
            if (local_idx == (PAGE_W-1)'(CFG_RO_PAGE)) begin
                allowed = 1'b0;
            end else if (local_idx == (PAGE_W-1)'(CFG_LOCK_PAGE) && lock) begin
                allowed = 1'b0;
            end
        end
    end

endmodule

// File: rtl/nvm_page_store.sv
module nvm_page_store
    import nvm_seq_pkg::*;
#(
    parameter int unsigned NUM_PAGES  = 32,
    parameter int unsigned PAGE_BYTES = 16,
    localparam int unsigned PAGE_W = $clog2(NUM_PAGES),
    localparam int unsigned OFF_W  = $clog2(PAGE_BYTES),
    localparam int unsigned ADDR_W = PAGE_W + OFF_W,
    localparam int unsigned DATA_W = PAGE_BYTES * 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              commit,
    input  logic              erase,
    input  logic [PAGE_W-1:0] page,
    input  logic [DATA_W-1:0] data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              lock_src
);

    logic [DATA_W-1:0] page_view [NUM_PAGES];

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        typedef struct packed {
            logic [DATA_W-1:0]     bytes;
            logic [PAGE_BYTES-1:0] used;
        } page_t;

        page_t pg_d, pg_q;
        logic  hit;

        assign hit          = commit && (page == PAGE_W'(p));
        assign page_view[p] = pg_q.bytes;

        always_comb begin
            pg_d = pg_q;
            if (hit) begin
                if (erase) begin
                    pg_d.bytes = '0;
                    pg_d.used  = '0;
                end else begin
                    for (int b = 0; b < PAGE_BYTES; b++) begin
                        if (!pg_q.used[b]) begin
                            pg_d.bytes[b*8 +: 8] = pg_q.bytes[b*8 +: 8] | data[b*8 +: 8];
                            pg_d.used[b]         = 1'b1;
                        end
                    end
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!por_n) begin
                pg_q <= '0;
            end else begin
                pg_q <= pg_d;
            end
        end
    end

    logic [DATA_W-1:0] rd_page;
    logic [OFF_W-1:0]  rd_off;

    assign rd_page  = page_view[rd_addr[ADDR_W-1:OFF_W]];
    assign rd_off   = rd_addr[OFF_W-1:0];
    assign rd_data  = rd_page[rd_off*8 +: 8];
    assign lock_src = page_view[CFG_LOCK_PAGE][0];

endmodule

// File: rtl/nvm_page_sequencer.sv
module nvm_page_sequencer
    import nvm_seq_pkg::*;
#(
    parameter int unsigned NUM_PAGES  = 32,
    parameter int unsigned PAGE_BYTES = 16,
    parameter int unsigned CYCLE_LEN  = 20,
    localparam int unsigned PAGE_W = $clog2(NUM_PAGES),
    localparam int unsigned OFF_W  = $clog2(PAGE_BYTES),
    localparam int unsigned ADDR_W = PAGE_W + OFF_W,
    localparam int unsigned DATA_W = PAGE_BYTES * 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              stop_evt,
    input  logic              prog_req,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [7:0]        erase_ctl,
    output logic              busy
);

    typedef struct packed {
        nvm_op_e           op;
        logic [PAGE_W-1:0] page;
        logic [DATA_W-1:0] data;
        logic [7:0]        ctl;
        logic              lock;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              tmr_start;
    logic              tmr_busy;
    logic              tmr_done;
    logic              lock_src;
    logic              erase_ok;
    logic              prog_ok;
    logic [PAGE_W-1:0] erase_page;
    logic [PAGE_W-1:0] prog_page;
    logic              prog_aligned;
    logic              op_is_erase;
    logic [PAGE_W-1:0] commit_page;

    assign erase_page   = seq_q.ctl[PAGE_W-1:0];
    assign prog_page    = prog_addr[ADDR_W-1:OFF_W];
    assign prog_aligned = (prog_addr[OFF_W-1:0] == '0);
    assign op_is_erase  = (seq_q.op == OP_ERASE);
    assign commit_page  = seq_q.page;

    nvm_page_guard #(.PAGE_W(PAGE_W)) u_erase_guard (
        .page    (erase_page),
        .lock    (seq_q.lock),
        .allowed (erase_ok)
    );

    nvm_page_guard #(.PAGE_W(PAGE_W)) u_prog_guard (
        .page    (prog_page),
        .lock    (seq_q.lock),
        .allowed (prog_ok)
    );

    nvm_cycle_timer #(.CYCLE_LEN(CYCLE_LEN)) u_timer (
        .clk   (clk),
        .por_n (por_n),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    nvm_page_store #(
        .NUM_PAGES  (NUM_PAGES),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_store (
        .clk      (clk),
        .por_n    (por_n),
        .commit   (tmr_done),
        .erase    (op_is_erase),
        .page     (seq_q.page),
        .data     (seq_q.data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .lock_src (lock_src)
    );

    always_comb begin
        seq_d     = seq_q;
        tmr_start = 1'b0;

        // completion of the running cycle
        if (tmr_done) begin
            if (seq_q.op == OP_ERASE) begin
                seq_d.ctl[ERASE_EN_BIT] = 1'b0;
            end
            seq_d.op = OP_NONE;
        end

        // an armed erase fires on Stop; it takes precedence over a program
        if (stop_evt && seq_q.ctl[ERASE_EN_BIT]) begin
            if (!tmr_busy && erase_ok) begin
                tmr_start  = 1'b1;
                seq_d.op   = OP_ERASE;
                seq_d.page = erase_page;
            end else begin
                seq_d.ctl[ERASE_EN_BIT] = 1'b0;
            end
        end else if (prog_req && prog_aligned && !tmr_busy && prog_ok) begin
            tmr_start  = 1'b1;
            seq_d.op   = OP_PROG;
            seq_d.page = prog_page;
            seq_d.data = prog_data;
        end

        // register write lands last, so a fresh value wins in the same cycle
        if (reg_wr && reg_addr == ERASE_CTL_ADDR) begin
            seq_d.ctl = reg_wdata & ERASE_CTL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            seq_q <= '0;
        end else if (!rst_n) begin
            seq_q      <= '0;
            seq_q.lock <= lock_src;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign erase_ctl = seq_q.ctl;
    assign busy      = tmr_busy;

endmodule

// File: rtl/nvm_page_sequencer_chk.sv
module nvm_page_sequencer_chk #(
    parameter int unsigned CYCLE_LEN = 20,
    parameter int unsigned PAGE_W    = 5,
    parameter int unsigned ADDR_W    = 9
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              op_erase,
    input logic              reg_wr,
    input logic [7:0]        reg_addr,
    input logic [7:0]        erase_ctl,
    input logic              stop_evt,
    input logic              prog_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic [PAGE_W-1:0] commit_page
);

    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= '0;
        end
    end

    AST_CTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        erase_ctl[6:5] == 2'b00); // R1

    AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(busy) |-> $past(stop_evt || prog_req)); // R2

    AST_BUSY_FIXED_LEN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!busy && run_q != 0) |-> run_q == CYCLE_LEN); // R3

    AST_ERASE_CLEARS_EN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (done && op_erase && !(reg_wr && reg_addr == 8'hE3)) |=> !erase_ctl[7]); // R4

    AST_NO_BIT_CLEAR: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ($stable(rd_addr) && !$past(done && op_erase)) |-> (($past(rd_data) & ~rd_data) == 8'h00)); // R5

    AST_RO_PAGE_NEVER_COMMITS: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        done |-> commit_page != PAGE_W'(15)); // R9

endmodule

bind nvm_page_sequencer nvm_page_sequencer_chk #(
    .CYCLE_LEN (CYCLE_LEN),
    .PAGE_W    (PAGE_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (tmr_done),
    .op_erase    (op_is_erase),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .erase_ctl   (erase_ctl),
    .stop_evt    (stop_evt),
    .prog_req    (prog_req),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .commit_page (commit_page)
);

// File: tb/nvm_page_sequencer_test.sv
module nvm_page_sequencer_test;

    localparam int CLK_PERIOD = 40;
    localparam int CYC        = 12;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic [7:0]   reg_wdata = '0;
    logic         stop_evt = 1'b0;
    logic         prog_req = 1'b0;
    logic [8:0]   prog_addr = '0;
    logic [127:0] prog_data = '0;
    logic [8:0]   rd_addr = '0;
    logic [7:0]   rd_data;
    logic [7:0]   erase_ctl;
    logic         busy;

    int checks = 0;
    int fails  = 0;

    localparam logic [127:0] PAT_A = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    localparam logic [127:0] PAT_B = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] PAT_C = 128'hcafef00d0badbeef1234567813579bdf;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_page_sequencer #(.CYCLE_LEN(CYC)) uut (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .stop_evt  (stop_evt),
        .prog_req  (prog_req),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .erase_ctl (erase_ctl),
        .busy      (busy)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called just after a falling edge; 16 reads of 1 time unit stay clear of the next rising edge
    task automatic read_page(input int pg, output logic [127:0] v);
        for (int b = 0; b < 16; b++) begin
            rd_addr = 9'(pg * 16 + b);
            #1;
            v[b*8 +: 8] = rd_data;
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic stop_pulse();
        @(negedge clk);
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
    endtask

    task automatic prog_issue(input int addr, input logic [127:0] d);
        @(negedge clk);
        prog_req = 1'b1; prog_addr = 9'(addr); prog_data = d;
        @(negedge clk);
        prog_req = 1'b0;
    endtask

    task automatic wait_idle(output int len);
        len = 0;
        while (busy && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [127:0] v;
        chk("R11 reset busy", 128'(busy), 128'd0);
        chk("R1 reset ctl", 128'(erase_ctl), 128'd0);
        read_page(16, v);
        chk("R5 erased page reads zero", v, 128'd0);
    endtask

    task automatic t_register();
        reg_write(8'hE3, 8'hFF);
        chk("R1 reserved bits masked", 128'(erase_ctl), 128'h9F);
        chk("R2 write alone no busy", 128'(busy), 128'd0);
        reg_write(8'hE2, 8'h00);
        chk("R1 other address ignored", 128'(erase_ctl), 128'h9F);
        reg_write(8'hE3, 8'h00);
        chk("R1 disarm", 128'(erase_ctl), 128'h00);
        stop_pulse();
        chk("R2 stop without enable", 128'(busy), 128'd0);
    endtask

    task automatic t_program();
        logic [127:0] v;
        int len;
        prog_issue(16*16, PAT_A);
        chk("R3 busy after accept", 128'(busy), 128'd1);
        wait_idle(len);
        chk("R3 busy length", 128'(len), 128'(CYC));
        read_page(16, v);
        chk("R5 page data placed", v, PAT_A);
        prog_issue(16*16, {128{1'b1}});
        wait_idle(len);
        read_page(16, v);
        chk("R6 second program no effect", v, PAT_A);
    endtask

    task automatic t_misaligned();
        logic [127:0] v;
        prog_issue(17*16 + 3, PAT_B);
        chk("R7 misaligned no busy", 128'(busy), 128'd0);
        read_page(17, v);
        chk("R7 misaligned store unchanged", v, 128'd0);
    endtask

    task automatic t_erase();
        logic [127:0] v;
        int len;
        reg_write(8'hE3, 8'h90);
        chk("R2 armed but no stop", 128'(busy), 128'd0);
        stop_pulse();
        chk("R2 stop starts erase", 128'(busy), 128'd1);
        wait_idle(len);
        chk("R3 erase busy length", 128'(len), 128'(CYC));
        read_page(16, v);
        chk("R4 erased page zero", v, 128'd0);
        chk("R4 enable self-cleared", 128'(erase_ctl), 128'h10);
        prog_issue(16*16, PAT_B);
        wait_idle(len);
        read_page(16, v);
        chk("R6 reprogram after erase", v, PAT_B);
    endtask

    task automatic t_busy_reject();
        logic [127:0] v;
        int len;
        prog_issue(18*16, PAT_C);
        prog_issue(19*16, PAT_A);
        reg_write(8'hE3, 8'h92);
        stop_pulse();
        chk("R8 stop during busy clears enable", 128'(erase_ctl), 128'h12);
        wait_idle(len);
        read_page(18, v);
        chk("R8 first program kept, no erase", v, PAT_C);
        read_page(19, v);
        chk("R8 program during busy rejected", v, 128'd0);
    endtask

    task automatic t_read_during_busy();
        logic [127:0] v;
        int len;
        prog_issue(20*16, PAT_A);
        chk("R11 busy running", 128'(busy), 128'd1);
        read_page(16, v);
        chk("R11 read during busy", v, PAT_B);
        reg_write(8'hE3, 8'h05);
        chk("R11 register write during busy", 128'(erase_ctl), 128'h05);
        wait_idle(len);
    endtask

    task automatic t_ro_page();
        logic [127:0] v;
        prog_issue(15*16, PAT_A);
        chk("R9 program of page 15 rejected", 128'(busy), 128'd0);
        read_page(15, v);
        chk("R9 page 15 unchanged", v, 128'd0);
        reg_write(8'hE3, 8'h8F);
        stop_pulse();
        chk("R9 erase of page 15 rejected", 128'(busy), 128'd0);
        chk("R12 rejected erase clears enable", 128'(erase_ctl), 128'h0F);
    endtask

    task automatic t_lock();
        logic [127:0] v;
        int len;
        prog_issue(14*16, 128'h01);
        chk("R10 page 14 writable before reset", 128'(busy), 128'd1);
        wait_idle(len);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_page(14, v);
        chk("R11 soft reset keeps store", v, 128'h01);
        read_page(16, v);
        chk("R11 soft reset keeps user page", v, PAT_B);
        reg_write(8'hE3, 8'h8E);
        stop_pulse();
        chk("R10 locked page erase rejected", 128'(busy), 128'd0);
        chk("R12 locked erase clears enable", 128'(erase_ctl), 128'h0E);
        read_page(14, v);
        chk("R10 locked page unchanged", v, 128'h01);
    endtask

    task automatic t_power_up();
        logic [127:0] v;
        int len;
        @(negedge clk); por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        read_page(16, v);
        chk("R11 power-up clears store", v, 128'd0);
        reg_write(8'hE3, 8'h8E);
        stop_pulse();
        chk("R10 lock gone after power-up", 128'(busy), 128'd1);
        wait_idle(len);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_register();
        t_program();
        t_misaligned();
        t_erase();
        t_busy_reject();
        t_read_during_busy();
        t_ro_page();
        t_lock();
        t_power_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule